// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between the host bus and the internal program and erase sequencers of a NOR flash. Every bus write cycle is decoded as a command byte, or as the second cycle of a two-cycle command. The block tracks the device mode, which is one of the following: idle with a chosen read source, program busy, erase busy, a suspend request pending, program suspended, erase suspended, or a program running or suspended inside an erase suspend. From that mode it drives the read-output mux select and a blocked-read flag. It issues one-cycle start, suspend and resume pulses to the two sequencers. It also holds the status byte.

Suspension works on two levels. An erase can be paused so that the host can read or program other blocks. A program started during that pause can itself be paused so that the host can read. Each suspended state accepts only a small set of commands and silently drops the rest. Ready and the suspend flags in the status byte follow the sequencers' pause acknowledges and the resume commands without host action. The sticky error bits are cleared by an explicit command.

Command codes are: FFh read array, 70h read status, 90h read identifier, 50h clear status, 40h program setup, 20h erase setup, D0h erase confirm / resume, B0h suspend. The command byte is bits [7:0] of the write data. Read select codes are: 0 array, 1 status, 2 identifier. Status bits are: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 supply-voltage error, 2 program suspended, 1..0 always 0.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read select is 0 (array), status reads 80h and no sequencer pulse is high.
- R2: In the idle mode FFh, 70h and 90h set the read select to 0, 1 and 2 respectively, and any unlisted byte leaves it unchanged.
- R3: 40h followed by a data write pulses pgm_start for one cycle after the second write, latches that write's address and data, selects status, and holds status bit 7 at 0 until pgm_done.
- R4: 20h followed by D0h pulses ers_start and latches the block address. 20h followed by any other byte cancels the setup without starting anything.
- R5: If vpp_ok is low at the second cycle of a program or erase, nothing starts, and bit 3 is set together with bit 4 (program) or bit 5 (erase).
- R6: A completion with the fail input high sets bit 4 (program) or bit 5 (erase). 50h in the idle mode clears bits 5, 4 and 3.
- R7: B0h during a busy operation pulses the matching suspend request and selects status. Bit 7 stays 0 until the pause acknowledge. The acknowledge then sets bit 7 and bit 2 (program) or bit 6 (erase).
- R8: While a program is suspended only FFh, 70h, 90h and D0h are accepted. Every other byte leaves the mode, read select and status unchanged.
- R9: D0h in a suspended state pulses the matching resume request, clears bit 2 or bit 6, clears bit 7 and selects status.
- R10: While an erase is suspended only D0h, 40h, FFh, 70h and 90h are accepted. Every other byte, including 20h, is ignored.
- R11: A program started during an erase suspend keeps bit 6 set. It can be suspended (bits 7, 6 and 2 all 1), and D0h then resumes the program, not the erase. When it completes, the mode returns to erase suspended (status C0h).
- R12: rd_blocked is 1 exactly when the read select is array and rd_blk equals the block of a suspended program or suspended erase.
- R13: During a busy operation only B0h and 70h have an effect. A read-array or setup byte is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | AW | Write address |
| bus_data | input | DW | Write data; command byte in [7:0] |
| rd_blk | input | BW | Block field of the current read address |
| vpp_ok | input | 1 | Programming supply within limits |
| pgm_done | input | 1 | Program sequencer finished |
| pgm_fail | input | 1 | Program result failed, valid with pgm_done |
| pgm_paused | input | 1 | Program sequencer reached its pause point |
| ers_done | input | 1 | Erase sequencer finished |
| ers_fail | input | 1 | Erase result failed, valid with ers_done |
| ers_paused | input | 1 | Erase sequencer reached its pause point |
| rd_sel | output | 2 | Read mux select: 0 array, 1 status, 2 identifier |
| rd_blocked | output | 1 | Array read hits a suspended block |
| status | output | 8 | Status byte |
| pgm_addr | output | AW | Latched program address |
| pgm_data | output | DW | Latched program data |
| ers_addr | output | AW | Latched erase address |
| pgm_start | output | 1 | Program start pulse |
| pgm_susp_req | output | 1 | Program suspend request pulse |
| pgm_resume | output | 1 | Program resume pulse |
| ers_start | output | 1 | Erase start pulse |
| ers_susp_req | output | 1 | Erase suspend request pulse |
| ers_resume | output | 1 | Erase resume pulse |

## Verification
A wrong mode register becomes visible one cycle after the next command write. A dropped or accepted byte shows at once as a changed rd_sel, as a start or resume pulse that should not fire, or as a status byte with the wrong ready or suspend flags. A mode that fails to return correctly from a nested program completes to idle (80h) instead of erase suspended (C0h), and the first status sample after pgm_done shows it. Errors in the block comparison show on rd_blocked in the same cycle that rd_blk changes.

// File: rtl/flash_cmd_pkg.sv
// Shared codes and types for the flash command interface controller.
// Assumes the command byte is bits [7:0] of the bus write data.
package flash_cmd_pkg;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_RD_IDENT  = 8'h90;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;
    localparam logic [7:0] OP_PGM_SETUP = 8'h40;
    localparam logic [7:0] OP_ERS_SETUP = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IDENT  = 2'd2
    } rd_sel_t;

    typedef enum logic [3:0] {
        M_IDLE, M_PGM, M_PGM_SREQ, M_PGM_SUSP,
        M_ERS, M_ERS_SREQ, M_ERS_SUSP,
        M_NPGM, M_NPGM_SREQ, M_NPGM_SUSP
    } mode_t;

    typedef struct packed {
        logic rd_array;
        logic rd_status;
        logic rd_ident;
        logic clr_stat;
        logic pgm_setup;
        logic ers_setup;
        logic confirm;
        logic suspend;
    } cmd_t;

    typedef struct packed {
        logic set_psus;
        logic clr_psus;
        logic set_esus;
        logic clr_esus;
        logic vpp_err;
        logic pgm_err;
        logic ers_err;
        logic clr_err;
    } sr_evt_t;
endpackage

// File: rtl/flash_cmd_decode.sv
// Command byte decoder: turns a byte into one-hot command flags.
// Assumes nothing about mode; legality is decided by the mode FSM.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       cmd
);
    // Compare the byte against every known opcode.
    always_comb begin
        cmd           = '0;
        cmd.rd_array  = (code == OP_RD_ARRAY);
        cmd.rd_status = (code == OP_RD_STATUS);
        cmd.rd_ident  = (code == OP_RD_IDENT);
        cmd.clr_stat  = (code == OP_CLR_STAT);
        cmd.pgm_setup = (code == OP_PGM_SETUP);
        cmd.ers_setup = (code == OP_ERS_SETUP);
        cmd.confirm   = (code == OP_CONFIRM);
        cmd.suspend   = (code == OP_SUSPEND);
    end
endmodule

// File: rtl/flash_mode_fsm.sv
// Mode tracker: holds the device mode, the read select, the two-cycle
// setup flags and the latched operation addresses; emits one-cycle
// sequencer pulses and status events. Assumes done/paused inputs are
// one-cycle pulses from the sequencers.
module flash_mode_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  cmd_t          cmd,
    input  logic          vpp_ok,
    input  logic          pgm_done,
    input  logic          pgm_fail,
    input  logic          pgm_paused,
    input  logic          ers_done,
    input  logic          ers_fail,
    input  logic          ers_paused,
    output mode_t         mode,
    output rd_sel_t       sel,
    output logic [AW-1:0] pgm_addr,
    output logic [DW-1:0] pgm_data,
    output logic [AW-1:0] ers_addr,
    output logic          pgm_start,
    output logic          pgm_susp_req,
    output logic          pgm_resume,
    output logic          ers_start,
    output logic          ers_susp_req,
    output logic          ers_resume,
    output sr_evt_t       evt
);
    mode_t   mode_n;
    rd_sel_t sel_n;
    logic    parm, parm_n, earm, earm_n;
    logic    lat_pgm, lat_ers;
    logic    ps_n, psr_n, pr_n, es_n, esr_n, er_n;
    logic    ers_op, op_done, op_fail;

    assign ers_op  = (mode == M_ERS) || (mode == M_ERS_SREQ);
    assign op_done = ers_op ? ers_done : pgm_done;
    assign op_fail = ers_op ? ers_fail : pgm_fail;

    // Next-state decision for mode, read select and pulses.
    always_comb begin
        mode_n = mode;  sel_n = sel;  parm_n = parm;  earm_n = earm;
        lat_pgm = 1'b0; lat_ers = 1'b0;
        ps_n = 1'b0; psr_n = 1'b0; pr_n = 1'b0;
        es_n = 1'b0; esr_n = 1'b0; er_n = 1'b0;
        evt = '0;
        case (mode)
            M_IDLE, M_ERS_SUSP: begin
                if (we && parm) begin
                    parm_n  = 1'b0;
                    sel_n   = SEL_STATUS;
                    lat_pgm = 1'b1;
                    if (vpp_ok) begin
                        ps_n   = 1'b1;
                        mode_n = (mode == M_IDLE) ? M_PGM : M_NPGM;
                    end else begin
                        evt.vpp_err = 1'b1;
                        evt.pgm_err = 1'b1;
                    end
                end else if (we && earm) begin
                    earm_n = 1'b0;
                    if (cmd.confirm) begin
                        sel_n   = SEL_STATUS;
                        lat_ers = 1'b1;
                        if (vpp_ok) begin
                            es_n   = 1'b1;
                            mode_n = M_ERS;
                        end else begin
                            evt.vpp_err = 1'b1;
                            evt.ers_err = 1'b1;
                        end
                    end
                end else if (we) begin
                    if (cmd.rd_array)  sel_n = SEL_ARRAY;
                    if (cmd.rd_status) sel_n = SEL_STATUS;
                    if (cmd.rd_ident)  sel_n = SEL_IDENT;
                    if (cmd.pgm_setup) begin
                        parm_n = 1'b1;
                        sel_n  = SEL_STATUS;
                    end
                    if (mode == M_IDLE) begin
                        if (cmd.ers_setup) begin
                            earm_n = 1'b1;
                            sel_n  = SEL_STATUS;
                        end
                        if (cmd.clr_stat) evt.clr_err = 1'b1;
                    end else if (cmd.confirm) begin
                        er_n         = 1'b1;
                        evt.clr_esus = 1'b1;
                        mode_n       = M_ERS;
                        sel_n        = SEL_STATUS;
                    end
                end
            end
            M_PGM, M_ERS, M_NPGM, M_PGM_SREQ, M_ERS_SREQ, M_NPGM_SREQ: begin
                if (op_done) begin
                    mode_n = (mode == M_NPGM || mode == M_NPGM_SREQ) ? M_ERS_SUSP : M_IDLE;
                    if (op_fail) begin
                        if (ers_op) evt.ers_err = 1'b1;
                        else        evt.pgm_err = 1'b1;
                    end
                end else if (mode == M_PGM_SREQ || mode == M_NPGM_SREQ) begin
                    if (pgm_paused) begin
                        mode_n       = (mode == M_PGM_SREQ) ? M_PGM_SUSP : M_NPGM_SUSP;
                        evt.set_psus = 1'b1;
                    end
                end else if (mode == M_ERS_SREQ) begin
                    if (ers_paused) begin
                        mode_n       = M_ERS_SUSP;
                        evt.set_esus = 1'b1;
                    end
                end else if (we && cmd.suspend) begin
                    sel_n = SEL_STATUS;
                    case (mode)
                        M_PGM:   begin psr_n = 1'b1; mode_n = M_PGM_SREQ;  end
                        M_NPGM:  begin psr_n = 1'b1; mode_n = M_NPGM_SREQ; end
                        default: begin esr_n = 1'b1; mode_n = M_ERS_SREQ;  end
                    endcase
                end else if (we && cmd.rd_status) begin
                    sel_n = SEL_STATUS;
                end
            end
            M_PGM_SUSP, M_NPGM_SUSP: begin
                if (we) begin
                    if (cmd.rd_array)  sel_n = SEL_ARRAY;
                    if (cmd.rd_status) sel_n = SEL_STATUS;
                    if (cmd.rd_ident)  sel_n = SEL_IDENT;
                    if (cmd.confirm) begin
                        pr_n         = 1'b1;
                        evt.clr_psus = 1'b1;
                        mode_n       = (mode == M_PGM_SUSP) ? M_PGM : M_NPGM;
                        sel_n        = SEL_STATUS;
                    end
                end
            end
            default: mode_n = M_IDLE;
        endcase
    end

    // Register mode, select, setup flags and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_IDLE;  sel <= SEL_ARRAY;
            parm <= 1'b0;    earm <= 1'b0;
            pgm_start <= 1'b0; pgm_susp_req <= 1'b0; pgm_resume <= 1'b0;
            ers_start <= 1'b0; ers_susp_req <= 1'b0; ers_resume <= 1'b0;
        end else begin
            mode <= mode_n;  sel <= sel_n;
            parm <= parm_n;  earm <= earm_n;
            pgm_start <= ps_n; pgm_susp_req <= psr_n; pgm_resume <= pr_n;
            ers_start <= es_n; ers_susp_req <= esr_n; ers_resume <= er_n;
        end
    end

    // Latch the program and erase targets on their second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_addr <= '0; pgm_data <= '0; ers_addr <= '0;
        end else begin
            if (lat_pgm) begin
                pgm_addr <= addr;
                pgm_data <= data;
            end
            if (lat_ers) ers_addr <= addr;
        end
    end
endmodule

// File: rtl/flash_status_reg.sv
// Status byte: suspend flags follow sequencer events, error flags are
// sticky until cleared; ready comes from the current mode.
module flash_status_reg
    import flash_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sr_evt_t evt,
    input  logic    ready,
    output logic [7:0] status
);
    logic esus, eerr, perr, verr, psus;

    // Update each status flag from its set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esus <= 1'b0; eerr <= 1'b0; perr <= 1'b0; verr <= 1'b0; psus <= 1'b0;
        end else begin
            if (evt.set_psus)      psus <= 1'b1;
            else if (evt.clr_psus) psus <= 1'b0;
            if (evt.set_esus)      esus <= 1'b1;
            else if (evt.clr_esus) esus <= 1'b0;
            if (evt.clr_err) begin
                eerr <= 1'b0; perr <= 1'b0; verr <= 1'b0;
            end else begin
                if (evt.ers_err) eerr <= 1'b1;
                if (evt.pgm_err) perr <= 1'b1;
                if (evt.vpp_err) verr <= 1'b1;
            end
        end
    end

    assign status = {ready, esus, eerr, perr, verr, psus, 2'b00};
endmodule

// File: rtl/flash_blk_guard.sv
// Read guard: flags an array read that falls in a suspended block.
// Assumes the block index is the top BW bits of an address.
module flash_blk_guard #(
    parameter int BW = 4
) (
    input  logic          sel_array,
    input  logic          psus,
    input  logic          esus,
    input  logic [BW-1:0] rd_blk,
    input  logic [BW-1:0] pgm_blk,
    input  logic [BW-1:0] ers_blk,
    output logic          blocked
);
    // Compare the read block with each suspended target.
    always_comb begin
        blocked = sel_array && ((psus && (rd_blk == pgm_blk)) ||
                                (esus && (rd_blk == ers_blk)));
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command interface controller, top level. Decodes bus writes,
// tracks the mode with two-level suspend, drives the read select and
// the sequencer pulses, and holds the status byte.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [BW-1:0] rd_blk,
    input  logic          vpp_ok,
    input  logic          pgm_done,
    input  logic          pgm_fail,
    input  logic          pgm_paused,
    input  logic          ers_done,
    input  logic          ers_fail,
    input  logic          ers_paused,
    output logic [1:0]    rd_sel,
    output logic          rd_blocked,
    output logic [7:0]    status,
    output logic [AW-1:0] pgm_addr,
    output logic [DW-1:0] pgm_data,
    output logic [AW-1:0] ers_addr,
    output logic          pgm_start,
    output logic          pgm_susp_req,
    output logic          pgm_resume,
    output logic          ers_start,
    output logic          ers_susp_req,
    output logic          ers_resume
);
    localparam int BLK_LO = AW - BW;

    cmd_t    cmd;
    mode_t   mode;
    rd_sel_t sel;
    sr_evt_t evt;
    logic    ready;

    flash_cmd_decode u_dec (.code(bus_data[7:0]), .cmd(cmd));

    flash_mode_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .data(bus_data),
        .cmd(cmd), .vpp_ok(vpp_ok),
        .pgm_done(pgm_done), .pgm_fail(pgm_fail), .pgm_paused(pgm_paused),
        .ers_done(ers_done), .ers_fail(ers_fail), .ers_paused(ers_paused),
        .mode(mode), .sel(sel),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_addr(ers_addr),
        .pgm_start(pgm_start), .pgm_susp_req(pgm_susp_req), .pgm_resume(pgm_resume),
        .ers_start(ers_start), .ers_susp_req(ers_susp_req), .ers_resume(ers_resume),
        .evt(evt)
    );

    // Ready is high whenever no sequencer is running.
    always_comb begin
        ready = (mode == M_IDLE) || (mode == M_PGM_SUSP) ||
                (mode == M_ERS_SUSP) || (mode == M_NPGM_SUSP);
    end

    flash_status_reg u_sr (.clk(clk), .rst_n(rst_n), .evt(evt), .ready(ready), .status(status));

    flash_blk_guard #(.BW(BW)) u_guard (
        .sel_array(sel == SEL_ARRAY), .psus(status[2]), .esus(status[6]),
        .rd_blk(rd_blk), .pgm_blk(pgm_addr[AW-1:BLK_LO]), .ers_blk(ers_addr[AW-1:BLK_LO]),
        .blocked(rd_blocked)
    );

    assign rd_sel = sel;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Assertion checker for flash_cmd_ctrl, bound to every instance.
module flash_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rd_sel,
    input logic       rd_blocked,
    input logic [7:0] status,
    input logic       pgm_start,
    input logic       ers_start,
    input logic       pgm_resume,
    input logic       ers_resume,
    input logic       pgm_paused,
    input logic       ers_paused
);
    // R3
    pgm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);
    // R4
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_start && ers_start));
    // R7
    psus_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(pgm_paused));
    // R7
    esus_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(ers_paused));
    // R9
    psus_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[2]) |-> pgm_resume);
    // R9
    esus_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> ers_resume);
    // R11
    susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !pgm_resume) |-> status[7]);
    // R12
    guard_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blocked |-> (rd_sel == 2'd0));
    // R1
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] == 2'b00);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_blocked(rd_blocked),
    .status(status), .pgm_start(pgm_start), .ers_start(ers_start),
    .pgm_resume(pgm_resume), .ers_resume(ers_resume),
    .pgm_paused(pgm_paused), .ers_paused(ers_paused)
);

// File: tb/sim_flash_cmd_ctrl.sv
// Bench for flash_cmd_ctrl: a vector table for idle read modes, then
// directed sequences for program, erase, suspend and nesting.
module sim_flash_cmd_ctrl;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic [BW-1:0] rd_blk = '0;
    logic vpp_ok = 1'b1;
    logic pgm_done = 1'b0, pgm_fail = 1'b0, pgm_paused = 1'b0;
    logic ers_done = 1'b0, ers_fail = 1'b0, ers_paused = 1'b0;
    logic [1:0] rd_sel;
    logic rd_blocked;
    logic [7:0] status;
    logic [AW-1:0] pgm_addr, ers_addr;
    logic [DW-1:0] pgm_data;
    logic pgm_start, pgm_susp_req, pgm_resume, ers_start, ers_susp_req, ers_resume;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .DW(DW), .BW(BW)) u0 (.*);

    // {command byte, expected rd_sel, expected status}
    localparam logic [17:0] VEC [0:7] = '{
        {8'h70, 2'd1, 8'h80}, {8'h90, 2'd2, 8'h80}, {8'hFF, 2'd0, 8'h80},
        {8'h12, 2'd0, 8'h80}, {8'h70, 2'd1, 8'h80}, {8'h50, 2'd1, 8'h80},
        {8'hB0, 2'd1, 8'h80}, {8'h90, 2'd2, 8'h80}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic [AW-1:0] a);
        @(negedge clk);
        bus_we = 1'b1; bus_data = d; bus_addr = a;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_pgm(input logic paused, input logic done, input logic fail);
        @(negedge clk);
        pgm_paused = paused; pgm_done = done; pgm_fail = fail;
        @(negedge clk);
        pgm_paused = 1'b0; pgm_done = 1'b0; pgm_fail = 1'b0;
    endtask

    task automatic pulse_ers(input logic paused, input logic done, input logic fail);
        @(negedge clk);
        ers_paused = paused; ers_done = done; ers_fail = fail;
        @(negedge clk);
        ers_paused = 1'b0; ers_done = 1'b0; ers_fail = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sel", rd_sel, 0);
        check("R1 status", status, 8'h80);
        check("R1 pulses", {pgm_start, pgm_susp_req, pgm_resume, ers_start, ers_susp_req, ers_resume}, 0);

        // R2 idle read modes, unknown bytes ignored
        for (int i = 0; i < 8; i++) begin
            wr({8'h00, VEC[i][17:10]}, '0);
            check("R2 sel", rd_sel, VEC[i][9:8]);
            check("R2 status", status, VEC[i][7:0]);
        end

        // R3 program start and completion
        wr(16'h0040, 20'h10000);
        check("R3 setup sel", rd_sel, 1);
        wr(16'hBEEF, 20'h12345);
        check("R3 start", pgm_start, 1);
        check("R3 addr", pgm_addr, 20'h12345);
        check("R3 data", pgm_data, 16'hBEEF);
        check("R3 busy", status, 8'h00);
        @(negedge clk);
        check("R3 one pulse", pgm_start, 0);
        // R13 read array ignored while busy
        wr(16'h00FF, '0);
        check("R13 sel", rd_sel, 1);
        pulse_pgm(0, 1, 0);
        check("R3 done", status, 8'h80);

        // R5 low supply at program confirm
        vpp_ok = 1'b0;
        wr(16'h0040, '0);
        wr(16'h1111, 20'h20000);
        check("R5 no start", pgm_start, 0);
        check("R5 status", status, 8'h98);
        vpp_ok = 1'b1;
        // R6 clear status
        wr(16'h0050, '0);
        check("R6 clear", status, 8'h80);

        // R6 program fail
        wr(16'h0040, '0);
        wr(16'h2222, 20'h20000);
        pulse_pgm(0, 1, 1);
        check("R6 pgm fail", status, 8'h90);
        wr(16'h0050, '0);

        // R4 erase start, fail, cancel
        wr(16'h0020, '0);
        wr(16'h00D0, 20'h30000);
        check("R4 start", ers_start, 1);
        check("R4 addr", ers_addr, 20'h30000);
        check("R4 busy", status, 8'h00);
        pulse_ers(0, 1, 1);
        check("R6 ers fail", status, 8'hA0);
        wr(16'h0050, '0);
        wr(16'h0020, '0);
        wr(16'h0033, 20'h30000);
        check("R4 cancel", {ers_start, status}, 9'h080);
        wr(16'h0090, '0);
        check("R4 idle after cancel", rd_sel, 2);

        // R7 program suspend
        wr(16'h0040, '0);
        wr(16'h5555, 20'h50000);
        wr(16'h00B0, '0);
        check("R7 req", pgm_susp_req, 1);
        check("R7 wait ack", status, 8'h00);
        pulse_pgm(1, 0, 0);
        check("R7 suspended", status, 8'h84);
        // R8 illegal bytes ignored while program suspended
        wr(16'h0040, '0);
        wr(16'h0012, 20'h60000);
        check("R8 no start", pgm_start, 0);
        wr(16'h0020, '0);
        check("R8 status", status, 8'h84);
        check("R8 sel", rd_sel, 1);
        wr(16'h00FF, '0);
        check("R8 read array", rd_sel, 0);
        // R12 guard
        rd_blk = 4'h5;
        #1 check("R12 same block", rd_blocked, 1);
        rd_blk = 4'h6;
        #1 check("R12 other block", rd_blocked, 0);
        // R9 resume program
        wr(16'h00D0, '0);
        check("R9 resume", pgm_resume, 1);
        check("R9 status", status, 8'h00);
        check("R9 sel", rd_sel, 1);
        pulse_pgm(0, 1, 0);

        // R10 erase suspend, 20h ignored
        wr(16'h0020, '0);
        wr(16'h00D0, 20'h70000);
        wr(16'h00B0, '0);
        check("R7 ers req", ers_susp_req, 1);
        pulse_ers(1, 0, 0);
        check("R7 ers suspended", status, 8'hC0);
        wr(16'h0020, '0);
        wr(16'h00D0, '0);
        check("R10 resume not start", {ers_resume, ers_start}, 2'b10);
        wr(16'h00B0, '0);
        pulse_ers(1, 0, 0);
        wr(16'h00FF, '0);
        rd_blk = 4'h7;
        #1 check("R12 erase block", rd_blocked, 1);

        // R11 nested program
        wr(16'h0040, '0);
        wr(16'h8888, 20'h80000);
        check("R11 start", pgm_start, 1);
        check("R11 status", status, 8'h40);
        wr(16'h00B0, '0);
        check("R11 req", pgm_susp_req, 1);
        pulse_pgm(1, 0, 0);
        check("R11 both", status, 8'hC4);
        wr(16'h00D0, '0);
        check("R11 resumes pgm", {pgm_resume, ers_resume}, 2'b10);
        check("R11 running", status, 8'h40);
        pulse_pgm(0, 1, 0);
        check("R11 back to erase susp", status, 8'hC0);
        wr(16'h00D0, '0);
        check("R9 ers resume", ers_resume, 1);
        check("R9 ers status", status, 8'h00);
        pulse_ers(0, 1, 0);
        check("R9 ers done", status, 8'h80);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule